// File: doc/BRIEF.md
# Three-Button Sequence Lock

This block watches three push buttons and opens a door solenoid for one cycle when the buttons are pressed in the order 3, then 2, then 1. On each clock edge it samples a 3-bit button vector, which is legally either all zero or has exactly one bit set. A 2-bit state register remembers how much of the sequence has been seen so far. A cycle with no button pressed changes nothing, so the user may pause for any length of time between digits.

The unlock strobe is a Mealy output. It is asserted combinationally in the same cycle that button 1 is held while the machine already holds the second correct digit. On the following edge the machine falls back to idle. A vector with two or more bits set counts as a wrong entry. The block is split into two modules under a thin top. The datapath classifies the buttons and drives the strobe. The control holds the state and tells the datapath when it is armed.

Top module: `seq_lock_top`

## Requirements
- R1: A synchronous active-high reset puts the machine in idle, so after reset the inputs 2 then 1 give no unlock, while 3, 2, 1 unlocks on the 1.
- R2: In idle, no button (000), button 1 (001) or button 2 (010) keeps the machine in idle. Button 3 (100) advances it. The bit encoding is bit0 = button 1, bit1 = button 2, bit2 = button 3.
- R3: After a correct first digit, no button or a repeated button 3 keeps that progress. Button 2 advances to the second digit, and button 1 returns to idle.
- R4: After a correct second digit, no button holds the state indefinitely. Button 2 or button 3 returns to idle.
- R5: `unlock` is 1 in exactly those cycles where the machine holds the second correct digit and the input is 001. It is 0 in every other cycle, and it changes in the same cycle as the input.
- R6: Any input with two or more bits set returns the machine to idle from any state, and `unlock` stays 0 in that cycle.
- R7: After an unlock the machine is in idle, so a further 001 gives no unlock until 3, 2 is entered again.
- R8: While `rst` is high, `unlock` is 0 even if the machine holds the second digit and 001 is pressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| buttons | input | 3 | Button vector: bit0 = button 1, bit1 = button 2, bit2 = button 3 |
| unlock | output | 1 | Solenoid strobe, combinational (Mealy) |

## Verification
Two events can fall in the same cycle: the unlock strobe and a synchronous reset. Both are driven by an armed machine that sees 001 while `rst` is high. The bench provokes this on purpose by entering 3, 2 and then asserting reset together with button 1. It expects the strobe to stay low, and it expects the machine to start from idle afterwards. The random stimulus also brings up this case and the case of an illegal multi-bit vector arriving while armed. Each one is judged against a bench-side model that advances one transition per clock.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;

  localparam int BTN_W = 3;

  typedef enum logic [1:0] {
    LOCK_IDLE   = 2'b00,
    LOCK_FIRST  = 2'b01,
    LOCK_SECOND = 2'b10
  } lockState_e;

  // Button classification handed from datapath to control
  typedef struct packed {
    logic none;
    logic hit1;
    logic hit2;
    logic hit3;
    logic bad;
  } btnClass_t;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic armed;
  } ctrlStrobe_t;

endpackage

// File: rtl/seq_lock_dp.sv
module seq_lock_dp
  import seq_lock_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [BTN_W-1:0] buttons,
  input  ctrlStrobe_t      ctrlStb,
  output btnClass_t        btnCls,
  output logic             unlock
);

  logic [$clog2(BTN_W+1)-1:0] pressCount;

  always_comb begin
    pressCount  = $bits(pressCount)'($countones(buttons));
    btnCls.none = (pressCount == 0);
    btnCls.bad  = (pressCount > 1);
    btnCls.hit1 = (pressCount == 1) && buttons[0];
    btnCls.hit2 = (pressCount == 1) && buttons[1];
    btnCls.hit3 = (pressCount == 1) && buttons[2];
  end

  assign unlock = ctrlStb.armed && btnCls.hit1 && !rst;

  // R5
  unlock_exact_btn_chk: assert property (@(posedge clk)
    unlock |-> (buttons == 3'b001));

  // R6
  bad_no_unlock_chk: assert property (@(posedge clk)
    ($countones(buttons) > 1) |-> !unlock);

  // R8
  rst_blocks_unlock_chk: assert property (@(posedge clk)
    rst |-> !unlock);

endmodule

// File: rtl/seq_lock_ctrl.sv
module seq_lock_ctrl
  import seq_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  btnClass_t   btnCls,
  output ctrlStrobe_t ctrlStb
);

  lockState_e stateQ, stateD;

  always_comb begin
    case (stateQ)
      LOCK_IDLE:   stateD = btnCls.hit3 ? LOCK_FIRST : LOCK_IDLE;
      LOCK_FIRST: begin
        if (btnCls.hit2)                    stateD = LOCK_SECOND;
        else if (btnCls.none || btnCls.hit3) stateD = LOCK_FIRST;
        else                                stateD = LOCK_IDLE;
      end
      LOCK_SECOND: stateD = btnCls.none ? LOCK_SECOND : LOCK_IDLE;
      default:     stateD = LOCK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= LOCK_IDLE;
    else     stateQ <= stateD;
  end

  assign ctrlStb.armed = (stateQ == LOCK_SECOND);

  // R1
  reset_to_idle_chk: assert property (@(posedge clk)
    rst |=> (stateQ == LOCK_IDLE));

  // R2
  idle_waits_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == LOCK_IDLE && !btnCls.hit3) |=> (stateQ == LOCK_IDLE));

  // R3
  first_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == LOCK_FIRST && (btnCls.none || btnCls.hit3)) |=> (stateQ == LOCK_FIRST));

  // R4
  second_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == LOCK_SECOND && btnCls.none) |=> (stateQ == LOCK_SECOND));

  // R6
  bad_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    btnCls.bad |=> (stateQ == LOCK_IDLE));

  // R7
  armed_hit_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrlStb.armed && btnCls.hit1) |=> (stateQ == LOCK_IDLE));

endmodule

// File: rtl/seq_lock_top.sv
module seq_lock_top
  import seq_lock_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [BTN_W-1:0] buttons,
  output logic             unlock
);

  btnClass_t   btnCls;
  ctrlStrobe_t ctrlStb;

  seq_lock_dp dp_i (
    .clk     (clk),
    .rst     (rst),
    .buttons (buttons),
    .ctrlStb (ctrlStb),
    .btnCls  (btnCls),
    .unlock  (unlock)
  );

  seq_lock_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .btnCls  (btnCls),
    .ctrlStb (ctrlStb)
  );

endmodule

// File: tb/seq_lock_top_tb_top.sv
module seq_lock_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] buttons = 3'b000;
  logic       unlock;

  int checks = 0;
  int fails  = 0;
  int mState = 0;   // model: 0 idle, 1 first, 2 second
  bit done   = 1'b0;

  always #4 clk = ~clk;

  seq_lock_top dut_i (.clk(clk), .rst(rst), .buttons(buttons), .unlock(unlock));

  function automatic int modelNext(int s, logic [2:0] b, logic r);
    if (r) return 0;
    if ($countones(b) > 1) return 0;
    case (s)
      0: return (b == 3'b100) ? 1 : 0;
      1: return (b == 3'b010) ? 2 : ((b == 3'b000 || b == 3'b100) ? 1 : 0);
      default: return (b == 3'b000) ? 2 : 0;
    endcase
  endfunction

  function automatic logic modelUnlock(int s, logic [2:0] b, logic r);
    return (!r && s == 2 && b == 3'b001);
  endfunction

  // Drive one cycle of input, check the Mealy output, advance the model.
  task automatic step(logic [2:0] b, logic r, string req);
    logic exp;
    @(negedge clk);
    buttons = b;
    rst     = r;
    #1;
    exp = modelUnlock(mState, b, r);
    checks++;
    if (unlock !== exp) begin
      fails++;
      $display("FAIL %s: buttons=%b rst=%b unlock=%b expected=%b", req, b, r, unlock, exp);
    end
    mState = modelNext(mState, b, r);
  endtask

  initial begin
    step(3'b000, 1'b1, "R1");
    step(3'b001, 1'b1, "R8");
    // R1: after reset, 2 then 1 does not open, 3 2 1 does
    step(3'b010, 1'b0, "R1");
    step(3'b001, 1'b0, "R1");
    step(3'b100, 1'b0, "R1");
    step(3'b010, 1'b0, "R1");
    step(3'b001, 1'b0, "R1");
    // R7: a further 1 after unlock does nothing
    step(3'b001, 1'b0, "R7");
    // R2: idle ignores 0, 1, 2
    step(3'b000, 1'b0, "R2");
    step(3'b010, 1'b0, "R2");
    step(3'b001, 1'b0, "R2");
    // R3: repeated 3 and pauses keep progress
    step(3'b100, 1'b0, "R3");
    step(3'b100, 1'b0, "R3");
    step(3'b000, 1'b0, "R3");
    step(3'b010, 1'b0, "R3");
    // R4: long pause while armed, then open
    for (int i = 0; i < 20; i++) step(3'b000, 1'b0, "R4");
    step(3'b001, 1'b0, "R5");
    // R3: 1 after first digit returns to idle
    step(3'b100, 1'b0, "R3");
    step(3'b001, 1'b0, "R3");
    step(3'b010, 1'b0, "R3");
    step(3'b001, 1'b0, "R3");
    // R4: 2 and 3 while armed return to idle
    step(3'b100, 1'b0, "R4");
    step(3'b010, 1'b0, "R4");
    step(3'b010, 1'b0, "R4");
    step(3'b001, 1'b0, "R4");
    step(3'b100, 1'b0, "R4");
    step(3'b010, 1'b0, "R4");
    step(3'b100, 1'b0, "R4");
    step(3'b010, 1'b0, "R4");
    step(3'b001, 1'b0, "R4");
    // R6: illegal vectors while armed, including one containing button 1
    step(3'b100, 1'b0, "R6");
    step(3'b010, 1'b0, "R6");
    step(3'b011, 1'b0, "R6");
    step(3'b001, 1'b0, "R6");
    step(3'b100, 1'b0, "R6");
    step(3'b111, 1'b0, "R6");
    step(3'b010, 1'b0, "R6");
    step(3'b001, 1'b0, "R6");
    // R8: reset collides with the opening press
    step(3'b100, 1'b0, "R8");
    step(3'b010, 1'b0, "R8");
    step(3'b001, 1'b1, "R8");
    step(3'b001, 1'b0, "R8");
    // Random phase, biased toward the sequence
    void'($urandom(32'd4711));
    for (int i = 0; i < 4000; i++) begin
      int pick;
      logic [2:0] b;
      logic r;
      pick = $urandom_range(0, 99);
      if (pick < 30)      b = 3'b000;
      else if (pick < 50) b = 3'b100;
      else if (pick < 70) b = 3'b010;
      else if (pick < 88) b = 3'b001;
      else                b = 3'($urandom_range(3, 7)) | 3'b011 & 3'($urandom_range(0, 7));
      r = ($urandom_range(0, 49) == 0);
      step(b, r, "R5");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule